// File: doc/BRIEF.md
# Block Check Code Generator and Checker

This unit computes the check codes that guard two kinds of frame block in a four-level FSK data modem. The short identity block carries three payload bytes protected by a 6-bit code. The header block carries ten payload bytes protected by a 16-bit code, and that code travels in the two bytes that follow. The host selects the block kind and the operating mode, then pulses `start_i`. It then feeds payload bytes one at a time, each on a `byte_valid_i` strobe, while `ready_o` is high. The unit shifts every byte into the selected code register, one bit per cycle, most significant bit first. When the last bit of the last byte has been absorbed, it pulses `done_o` and presents the code on `code_o`.

In generate mode the host places the code into the outgoing block. In check mode the host also drives the received code on `ref_code_i`, and `match_o` rises together with `done_o` when the computed and received codes agree.

The controller is a four-state machine:
- `ST_IDLE`: nothing in progress.
- `ST_WAIT`: a byte is awaited and `ready_o` is high.
- `ST_SHIFT`: eight cycles of bit processing.
- `ST_DONE`: a one-cycle completion state.

Transitions:
- start: any state to `ST_WAIT`, clearing everything.
- accept: `ST_WAIT` to `ST_SHIFT` on a strobed byte.
- next-byte: `ST_SHIFT` to `ST_WAIT` after the eighth bit of a byte that is not the last.
- finish: `ST_SHIFT` to `ST_DONE` after the eighth bit of the last byte.
- retire: `ST_DONE` to `ST_IDLE`.

Top module: `blkcode_unit`

## Requirements
- R1: After reset, `ready_o`, `done_o` and `match_o` are 0 and `code_o` is 0.
- R2: A `start_i` pulse in any state clears the code register and the byte count, latches `kind_i` and `mode_i`, and makes `ready_o` high on the next cycle. A block in progress is abandoned, and a start in the same cycle as a strobed byte wins over that byte.
- R3: With `kind_i`=0 (identity), bytes 0, 1 and 2 are covered, with bit 7 of byte 0 entering first. The code is the remainder of x^6·M(x) modulo x^6+x^4+x^3+1, XORed with 6'b111111. It appears on `code_o[5:0]` with the x^5 coefficient at bit 5, and `code_o[15:6]` is 0. Examples: an all-zero message gives 6'h3F, and bytes 00,00,01 give 6'h26.
- R4: With `kind_i`=1 (header), bytes 0 to 9 are covered, MSB first. The code is the remainder of x^16·M(x) modulo x^16+x^12+x^5+1, with a zero start value and no final inversion. It appears on `code_o[15:0]`, and an all-zero header gives 16'h0000.
- R5: `ready_o` is high while a byte is awaited. A byte is taken when `ready_o` and `byte_valid_i` are both high. `ready_o` then stays low for exactly 8 cycles and rises again after the 8th bit.
- R6: `byte_valid_i` and `byte_i` have no effect while `ready_o` is low.
- R7: `done_o` is a one-cycle pulse, 8 cycles after the cycle in which the last byte was taken. `code_o` is valid during that pulse and holds its value until the next completion.
- R8: With `mode_i`=1 (check), `match_o` is high during the `done_o` cycle exactly when the code equals `ref_code_i`. For the identity block only `ref_code_i[5:0]` is compared. For the header block the full 16 bits are compared, with byte 10 in bits 15:8 and byte 11 in bits 7:0. With `mode_i`=0 (generate), `match_o` stays 0.
- R9: `match_o` is never high outside a `done_o` cycle, and `ready_o` and `done_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new block; clears state and latches kind and mode |
| kind_i | input | 1 | Block kind: 0 identity (6-bit code), 1 header (16-bit code) |
| mode_i | input | 1 | Operating mode: 0 generate, 1 check |
| byte_valid_i | input | 1 | Strobe for `byte_i` |
| byte_i | input | 8 | Payload byte |
| ref_code_i | input | 16 | Received code for comparison in check mode |
| ready_o | output | 1 | Unit can take a byte this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| match_o | output | 1 | Check mode: computed code equals `ref_code_i` |
| code_o | output | 16 | Computed code, right-aligned |

## Verification
The hardest situations to reach are those in which the host misbehaves in the middle of a byte. One case is strobes arriving during the eight shift cycles; the other is a new start arriving halfway through a block. The bench holds `byte_valid_i` high with inverted data during every shift window and confirms that the final code matches only the clean message. It also abandons an identity block after one byte and restarts as a header block in check mode. Code values are checked against a long-division model in the bench, and against hand-derived constants for the all-zero and single-one messages.

// File: rtl/blkcode_pkg.sv
package blkcode_pkg;
    localparam int BYTE_W    = 8;
    localparam int CODE_W    = 16;

    localparam int ID_W      = 6;
    localparam int ID_BYTES  = 3;
    localparam logic [ID_W-1:0] ID_POLY = 6'h19;
    localparam logic [ID_W-1:0] ID_XOR  = 6'h3F;

    localparam int HDR_W     = 16;
    localparam int HDR_BYTES = 10;
    localparam logic [HDR_W-1:0] HDR_POLY = 16'h1021;
    localparam logic [HDR_W-1:0] HDR_XOR  = 16'h0000;

    localparam int BCNT_W = $clog2(HDR_BYTES + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } bc_state_e;

    typedef enum logic {
        BLK_ID  = 1'b0,
        BLK_HDR = 1'b1
    } blk_kind_e;
endpackage

// File: rtl/bc_crc_lane.sv
module bc_crc_lane #(
    parameter int              W         = 16,
    parameter logic [W-1:0]    POLY      = '0,
    parameter logic [W-1:0]    FINAL_XOR = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         step_i,
    input  logic         bit_i,
    output logic [W-1:0] code_nxt_o
);
    logic [W-1:0] rem_q;
    logic [W-1:0] rem_nxt;
    logic         fb;

    always_comb begin
        fb = rem_q[W-1] ^ bit_i;
        if (step_i) begin
            rem_nxt = {rem_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end else begin
            rem_nxt = rem_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (clear_i) begin
            rem_q <= '0;
        end else begin
            rem_q <= rem_nxt;
        end
    end

    assign code_nxt_o = rem_nxt ^ FINAL_XOR;

    // R2
    lane_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (rem_q == '0));
endmodule

// File: rtl/bc_serializer.sv
module bc_serializer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              step_i,
    output logic              bit_o,
    output logic              last_bit_o
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (clear_i) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            sh_q  <= byte_i;
            cnt_q <= '0;
        end else if (step_i) begin
            sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bit_o      = sh_q[BYTE_W-1];
    assign last_bit_o = (cnt_q == LAST);

    // R5
    ser_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clear_i) |=> (cnt_q == '0));
endmodule

// File: rtl/bc_ctrl.sv
module bc_ctrl
    import blkcode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      kind_i,
    input  logic      mode_i,
    input  logic      byte_valid_i,
    input  logic      last_bit_i,
    output blk_kind_e kind_q,
    output logic      mode_q,
    output logic      clear_o,
    output logic      load_o,
    output logic      step_o,
    output logic      finish_o,
    output logic      ready_o,
    output logic      done_o
);
    localparam logic [BCNT_W-1:0] ID_N  = BCNT_W'(ID_BYTES);
    localparam logic [BCNT_W-1:0] HDR_N = BCNT_W'(HDR_BYTES);

    bc_state_e         state_q, state_nxt;
    logic [BCNT_W-1:0] bcnt_q;
    logic              last_byte;

    assign last_byte = (bcnt_q == ((kind_q == BLK_HDR) ? HDR_N : ID_N));

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_nxt = ST_WAIT;
            ST_WAIT:  if (start_i) state_nxt = ST_WAIT;
                      else if (byte_valid_i) state_nxt = ST_SHIFT;
            ST_SHIFT: if (start_i) state_nxt = ST_WAIT;
                      else if (last_bit_i && last_byte) state_nxt = ST_DONE;
                      else if (last_bit_i) state_nxt = ST_WAIT;
            ST_DONE:  if (start_i) state_nxt = ST_WAIT;
                      else state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bcnt_q  <= '0;
            kind_q  <= BLK_ID;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_nxt;
            if (start_i) begin
                bcnt_q <= '0;
                kind_q <= blk_kind_e'(kind_i);
                mode_q <= mode_i;
            end else if (load_o) begin
                bcnt_q <= bcnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        clear_o  = start_i;
        ready_o  = 1'b0;
        done_o   = 1'b0;
        load_o   = 1'b0;
        step_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_WAIT:  begin
                ready_o = 1'b1;
                load_o  = byte_valid_i && !start_i;
            end
            ST_SHIFT: step_o = !start_i;
            ST_DONE:  done_o = 1'b1;
            default:  ;
        endcase
        finish_o = step_o && last_bit_i && last_byte;
    end

    // R5
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && byte_valid_i && !start_i) |=> !ready_o);
    // R2
    start_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> ready_o);
    // R7
    finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |=> done_o);
endmodule

// File: rtl/blkcode_unit.sv
module blkcode_unit
    import blkcode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              kind_i,
    input  logic              mode_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [CODE_W-1:0] ref_code_i,
    output logic              ready_o,
    output logic              done_o,
    output logic              match_o,
    output logic [CODE_W-1:0] code_o
);
    blk_kind_e        kind_q;
    logic             mode_q;
    logic             clear, load, step, finish, last_bit, ser_bit;
    logic [ID_W-1:0]  id_code_nxt;
    logic [HDR_W-1:0] hdr_code_nxt;
    logic [CODE_W-1:0] code_q;

    bc_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .kind_i       (kind_i),
        .mode_i       (mode_i),
        .byte_valid_i (byte_valid_i),
        .last_bit_i   (last_bit),
        .kind_q       (kind_q),
        .mode_q       (mode_q),
        .clear_o      (clear),
        .load_o       (load),
        .step_o       (step),
        .finish_o     (finish),
        .ready_o      (ready_o),
        .done_o       (done_o)
    );

    bc_serializer #(.BYTE_W(BYTE_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .load_i     (load),
        .byte_i     (byte_i),
        .step_i     (step),
        .bit_o      (ser_bit),
        .last_bit_o (last_bit)
    );

    bc_crc_lane #(.W(ID_W), .POLY(ID_POLY), .FINAL_XOR(ID_XOR)) u_id_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .step_i     (step),
        .bit_i      (ser_bit),
        .code_nxt_o (id_code_nxt)
    );

    bc_crc_lane #(.W(HDR_W), .POLY(HDR_POLY), .FINAL_XOR(HDR_XOR)) u_hdr_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .step_i     (step),
        .bit_i      (ser_bit),
        .code_nxt_o (hdr_code_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (finish) begin
            code_q <= (kind_q == BLK_HDR) ? CODE_W'(hdr_code_nxt)
                                          : CODE_W'(id_code_nxt);
        end
    end

    always_comb begin
        code_o  = code_q;
        match_o = 1'b0;
        if (done_o && mode_q) begin
            if (kind_q == BLK_HDR) begin
                match_o = (code_q[HDR_W-1:0] == ref_code_i[HDR_W-1:0]);
            end else begin
                match_o = (code_q[ID_W-1:0] == ref_code_i[ID_W-1:0]);
            end
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> done_o);
    // R9
    match_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> done_o);
    // R9
    ready_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && done_o));
    // R3
    id_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && kind_q == BLK_ID) |-> (code_o[CODE_W-1:ID_W] == '0));
endmodule

// File: tb/blkcode_unit_bench.sv
`timescale 1ns/1ps
module blkcode_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, kind_i = 1'b0, mode_i = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [15:0] ref_code_i = '0;
    logic        ready_o, done_o, match_o;
    logic [15:0] code_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] msg [0:9];

    always #2.5 clk = ~clk;

    blkcode_unit u_blkcode_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
        .mode_i(mode_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
        .ref_code_i(ref_code_i), .ready_o(ready_o), .done_o(done_o),
        .match_o(match_o), .code_o(code_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] ref6(input logic [23:0] m);
        logic [29:0] v;
        v = {m, 6'b0};
        for (int i = 29; i >= 6; i--) if (v[i]) v[i-:7] ^= 7'b1011001;
        return v[5:0] ^ 6'h3F;
    endfunction

    function automatic logic [15:0] ref16(input logic [79:0] m);
        logic [95:0] v;
        v = {m, 16'b0};
        for (int i = 95; i >= 16; i--) if (v[i]) v[i-:17] ^= 17'h11021;
        return v[15:0];
    endfunction

    function automatic logic [23:0] pack3();
        return {msg[0], msg[1], msg[2]};
    endfunction

    function automatic logic [79:0] pack10();
        logic [79:0] r;
        r = '0;
        for (int i = 0; i < 10; i++) r = {r[71:0], msg[i]};
        return r;
    endfunction

    task automatic start_block(input logic k, input logic m);
        @(negedge clk);
        start_i = 1'b1; kind_i = k; mode_i = m;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic noisy);
        int guard;
        guard = 0;
        while (!ready_o && guard < 40) begin @(negedge clk); guard++; end
        byte_valid_i = 1'b1; byte_i = b;
        @(negedge clk);
        if (noisy) begin
            byte_i = ~b;
            for (int k = 0; k < 7; k++) @(negedge clk);
        end
        byte_valid_i = 1'b0; byte_i = 8'h00;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done_o && lat < 60) begin @(negedge clk); lat++; end
    endtask

    task automatic run_block(input logic k, input logic m, input logic noisy,
                             output logic [15:0] code, output logic mt,
                             output int lat);
        start_block(k, m);
        for (int i = 0; i < (k ? 10 : 3); i++) send_byte(msg[i], noisy);
        if (noisy) lat = 8; else wait_done(lat);
        if (noisy) begin int l2; wait_done(l2); end
        code = code_o; mt = match_o;
    endtask

    task automatic t_reset();
        chk("R1", "ready", ready_o, 0);
        chk("R1", "done", done_o, 0);
        chk("R1", "match", match_o, 0);
        chk("R1", "code", code_o, 0);
    endtask

    task automatic t_id_codes();
        logic [15:0] c; logic mt; int lat;
        for (int i = 0; i < 10; i++) msg[i] = 8'h00;
        run_block(1'b0, 1'b0, 1'b0, c, mt, lat);
        chk("R3", "id zero msg", c, 16'h003F);
        chk("R7", "done latency", lat, 8);
        msg[2] = 8'h01;
        run_block(1'b0, 1'b0, 1'b0, c, mt, lat);
        chk("R3", "id single one", c, 16'h0026);
        msg[0] = 8'hA5; msg[1] = 8'h3C; msg[2] = 8'h7E;
        run_block(1'b0, 1'b0, 1'b0, c, mt, lat);
        chk("R3", "id pattern", c, {10'b0, ref6(pack3())});
        chk("R8", "gen mode match low", mt, 0);
    endtask

    task automatic t_hdr_codes();
        logic [15:0] c; logic mt; int lat;
        for (int i = 0; i < 10; i++) msg[i] = 8'h00;
        run_block(1'b1, 1'b0, 1'b0, c, mt, lat);
        chk("R4", "hdr zero msg", c, 16'h0000);
        for (int i = 0; i < 10; i++) msg[i] = 8'(8'h31 + i * 13);
        run_block(1'b1, 1'b0, 1'b0, c, mt, lat);
        chk("R4", "hdr pattern", c, ref16(pack10()));
    endtask

    task automatic t_ready_timing();
        int lows;
        start_block(1'b0, 1'b0);
        chk("R5", "ready after start", ready_o, 1);
        byte_valid_i = 1'b1; byte_i = 8'h5A;
        @(negedge clk);
        byte_valid_i = 1'b0;
        lows = 0;
        for (int k = 0; k < 8; k++) begin
            if (!ready_o) lows++;
            @(negedge clk);
        end
        chk("R5", "ready low cycles", lows, 8);
        chk("R5", "ready back high", ready_o, 1);
    endtask

    task automatic t_ignore();
        logic [15:0] c; logic mt; int lat;
        msg[0] = 8'hC3; msg[1] = 8'h0F; msg[2] = 8'h99;
        run_block(1'b0, 1'b0, 1'b1, c, mt, lat);
        chk("R6", "id noisy strobes", c, {10'b0, ref6(pack3())});
        for (int i = 0; i < 10; i++) msg[i] = 8'(8'hE1 ^ (i * 7));
        run_block(1'b1, 1'b0, 1'b1, c, mt, lat);
        chk("R6", "hdr noisy strobes", c, ref16(pack10()));
    endtask

    task automatic t_done_pulse();
        logic [15:0] held;
        held = code_o;
        @(negedge clk);
        chk("R7", "done one cycle", done_o, 0);
        chk("R7", "code held", code_o, held);
        repeat (3) @(negedge clk);
        chk("R7", "code still held", code_o, held);
    endtask

    task automatic t_check_mode();
        logic [15:0] c; logic mt; int lat;
        for (int i = 0; i < 10; i++) msg[i] = 8'(i * 29 + 3);
        ref_code_i = ref16(pack10());
        run_block(1'b1, 1'b1, 1'b0, c, mt, lat);
        chk("R8", "hdr good match", mt, 1);
        ref_code_i = ref16(pack10()) ^ 16'h0100;
        run_block(1'b1, 1'b1, 1'b0, c, mt, lat);
        chk("R8", "hdr bad no match", mt, 0);
        msg[0] = 8'h12; msg[1] = 8'h34; msg[2] = 8'h56;
        ref_code_i = {10'h3FF, ref6(pack3())};
        run_block(1'b0, 1'b1, 1'b0, c, mt, lat);
        chk("R8", "id match low six bits", mt, 1);
        ref_code_i = {10'h000, ref6(pack3()) ^ 6'h20};
        run_block(1'b0, 1'b1, 1'b0, c, mt, lat);
        chk("R8", "id bad no match", mt, 0);
        @(negedge clk);
        chk("R9", "match low after done", match_o, 0);
    endtask

    task automatic t_abort();
        logic [15:0] c; logic mt; int lat;
        start_block(1'b0, 1'b0);
        send_byte(8'hFF, 1'b0);
        for (int i = 0; i < 10; i++) msg[i] = 8'(8'h77 + i);
        ref_code_i = ref16(pack10());
        start_i = 1'b1; kind_i = 1'b1; mode_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2", "ready after restart", ready_o, 1);
        for (int i = 0; i < 10; i++) send_byte(msg[i], 1'b0);
        wait_done(lat);
        c = code_o; mt = match_o;
        chk("R2", "restart hdr code", c, ref16(pack10()));
        chk("R2", "restart check match", mt, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_id_codes();
        t_done_pulse();
        t_hdr_codes();
        t_ready_timing();
        t_ignore();
        t_check_mode();
        t_abort();
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule